// File: doc/BRIEF.md
# Stack Push/Pop Micro-Sequencer

This block turns one already-decoded compressed stack instruction into a sequence of single-word memory operations. The instruction either saves a group of callee-saved registers below the stack pointer, or restores them and then releases the frame. A request carries five fields: the operation kind, a 4-bit list code, an extra frame adjustment in bytes, a flag that selects 32-bit or 64-bit register width, and a flag for the reduced register file. It also carries the current stack pointer value.

Once a request is accepted, the sequencer works through the selected registers one at a time. For a save it reads each register through a read port and stores it. For a restore it issues a load and writes the returned word back through the register write port. When the walk is complete, it writes the new stack pointer. The return variants can then clear a0 and redirect the PC to the restored return address. A list code that is not valid is rejected with a one-cycle illegal pulse, and no other activity follows.

Top module: `pushpop_seq`

## Requirements
- R1: The list code selects registers cumulatively.
  - Codes 0 to 3 select nothing.
  - Code 4 selects x1 (ra).
  - Code 5 adds x8, and code 6 adds x9.
  - Each code from 7 to 14 adds one register, from x18 up to x25.
  - Code 15 adds both x26 and x27.
- R2: A request is rejected in two cases: the list code is below 4, or the reduced flag is set and the code is above 6. When rejected, `illegal` is high for exactly one cycle, in the cycle after acceptance. There is no memory request, no register write and no redirect.
- R3: Each access moves one register word. The word is 4 bytes when `req_wide`=0 and 8 bytes when `req_wide`=1, and `mem_wide` follows that flag during the whole sequence.
- R4: The frame size is the count of listed registers times the word size, rounded up to a multiple of 16, plus `req_extra`.
- R5: Registers are visited from the highest register number down to the lowest. The address drops by one word size after each access.
- R6: Push (`req_op`=0) works as follows.
  - The first store goes to sp − word size.
  - The data of each store is the value read from the register being stored.
  - After the last store, x2 is written with sp − frame size.
- R7: Pop (`req_op`=1) works as follows.
  - The first load comes from sp + frame size − word size.
  - Each load result is written to its register.
  - After the last load, x2 is written with sp + frame size.
- R8: Pop-and-return (`req_op`=2) and pop-and-return-zero (`req_op`=3) redirect after the x2 write. The redirect is a one-cycle `pc_valid` pulse, with `pc_target` equal to the value restored into x1. The zero variant writes 0 to x10 between the x2 write and the redirect.
- R9: While `mem_valid` is high and `mem_ready` is low, the request keeps its address and direction. Exactly one access is issued per handshake.
- R10: A load result is written to the register file only in a cycle where `mem_rvalid` is high.
- R11: The two flags behave as follows.
  - `busy` rises after a legal acceptance and stays high until the redirect or final register write has been issued.
  - `req_ready` is low while busy, and no request is taken then.
  - While idle, there is no memory request, no register write and no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_op | input | 2 | 0 push, 1 pop, 2 pop-return, 3 pop-return-zero |
| req_list | input | 4 | Register list code |
| req_extra | input | ADJ_W | Extra frame adjustment in bytes |
| req_wide | input | 1 | 1 = 8-byte words, 0 = 4-byte words |
| req_reduced | input | 1 | Reduced register file |
| req_sp | input | XLEN | Stack pointer value at request |
| busy | output | 1 | Sequence in progress |
| illegal | output | 1 | Rejected request pulse |
| rf_raddr | output | 5 | Register read address |
| rf_rdata | input | XLEN | Register read data |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 5 | Register write address |
| rf_wdata | output | XLEN | Register write data |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_write | output | 1 | 1 = store, 0 = load |
| mem_wide | output | 1 | Word size of the access |
| mem_addr | output | XLEN | Access address |
| mem_wdata | output | XLEN | Store data |
| mem_rvalid | input | 1 | Load result valid |
| mem_rdata | input | XLEN | Load result |
| pc_valid | output | 1 | PC redirect pulse |
| pc_target | output | XLEN | Redirect target |

## Verification
The bench builds the block with XLEN=64 and ADJ_W=8, so both word sizes can be driven through the mode flag on one instance. The longest list, 13 registers at 8 bytes, gives a frame that needs rounding, and the extra field reaches adjustments beyond the rounded frame. An irregular ready pattern and variable load latency put stalls and waits between every access. Together these exercise the hold and writeback rules as well as the reduced-file cut-off at code 6.

// File: rtl/pushpop_pkg.sv
package pushpop_pkg;
  typedef enum logic [1:0] {
    OP_PUSH    = 2'd0,
    OP_POP     = 2'd1,
    OP_POPRET  = 2'd2,
    OP_POPRETZ = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_MEM, S_RESP, S_SP, S_ZERO, S_RET
  } seq_state_e;

  localparam int NREGS  = 32;
  localparam int IDX_W  = $clog2(NREGS);
  localparam int REG_RA = 1;
  localparam int REG_SP = 2;
  localparam int REG_A0 = 10;
endpackage

// File: rtl/pushpop_listdec.sv
module pushpop_listdec
  import pushpop_pkg::*;
(
  input  logic [3:0]       code,
  input  logic             reduced,
  output logic [NREGS-1:0] bitmap,
  output logic [3:0]       count,
  output logic             bad
);
  localparam int SAVED_LO = 18;   // first of the upper saved group

  always_comb begin
    bitmap = '0;
    if (code >= 4'd4) bitmap[REG_RA] = 1'b1;
    if (code >= 4'd5) bitmap[8]      = 1'b1;
    if (code >= 4'd6) bitmap[9]      = 1'b1;
    for (int k = 7; k <= 14; k++) begin
      if (code >= 4'(k)) bitmap[SAVED_LO + k - 7] = 1'b1;
    end
    if (code == 4'd15) bitmap[27:26] = 2'b11;
  end

  always_comb begin
    count = '0;
    for (int i = 0; i < NREGS; i++) count = count + 4'(bitmap[i]);
  end

  assign bad = (code < 4'd4) || (reduced && (code > 4'd6));
endmodule

// File: rtl/pushpop_frame.sv
module pushpop_frame #(
  parameter int XLEN  = 64,
  parameter int ADJ_W = 8
) (
  input  logic [3:0]       count,
  input  logic             wide,
  input  logic [ADJ_W-1:0] extra,
  output logic [XLEN-1:0]  total
);
  localparam int BYTES_W = 8;

  logic [BYTES_W-1:0] bytes_raw;
  logic [BYTES_W-1:0] bytes_rnd;

  assign bytes_raw = wide ? {1'b0, count, 3'b000} : {2'b00, count, 2'b00};
  assign bytes_rnd = (bytes_raw + 8'd15) & 8'hF0;
  assign total     = XLEN'(bytes_rnd) + XLEN'(extra);
endmodule

// File: rtl/pushpop_pick.sv
module pushpop_pick
  import pushpop_pkg::*;
(
  input  logic [NREGS-1:0] vec,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/pushpop_seq.sv
module pushpop_seq
  import pushpop_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int ADJ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [3:0]       req_list,
  input  logic [ADJ_W-1:0] req_extra,
  input  logic             req_wide,
  input  logic             req_reduced,
  input  logic [XLEN-1:0]  req_sp,
  output logic             busy,
  output logic             illegal,
  output logic [4:0]       rf_raddr,
  input  logic [XLEN-1:0]  rf_rdata,
  output logic             rf_we,
  output logic [4:0]       rf_waddr,
  output logic [XLEN-1:0]  rf_wdata,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic             mem_write,
  output logic             mem_wide,
  output logic [XLEN-1:0]  mem_addr,
  output logic [XLEN-1:0]  mem_wdata,
  input  logic             mem_rvalid,
  input  logic [XLEN-1:0]  mem_rdata,
  output logic             pc_valid,
  output logic [XLEN-1:0]  pc_target
);
  seq_state_e       state_q, state_d;
  op_e              op_q, op_d;
  logic             wide_q, wide_d;
  logic [NREGS-1:0] pend_q, pend_d;
  logic [XLEN-1:0]  addr_q, addr_d;
  logic [XLEN-1:0]  spnew_q, spnew_d;
  logic [XLEN-1:0]  ra_q, ra_d;
  logic             ill_q, ill_d;
  logic             dat_en;

  logic [NREGS-1:0] dec_map;
  logic [3:0]       dec_cnt;
  logic             dec_bad;
  logic [XLEN-1:0]  frame;
  logic [IDX_W-1:0] cur;
  logic [NREGS-1:0] pend_clr;
  logic [XLEN-1:0]  step_in, step_q;

  pushpop_listdec u_dec (
    .code(req_list), .reduced(req_reduced),
    .bitmap(dec_map), .count(dec_cnt), .bad(dec_bad)
  );

  pushpop_frame #(.XLEN(XLEN), .ADJ_W(ADJ_W)) u_frame (
    .count(dec_cnt), .wide(req_wide), .extra(req_extra), .total(frame)
  );

  pushpop_pick u_pick (.vec(pend_q), .idx(cur));

  assign step_in  = req_wide ? XLEN'(8) : XLEN'(4);
  assign step_q   = wide_q   ? XLEN'(8) : XLEN'(4);
  assign pend_clr = pend_q & ~(NREGS'(1) << cur);

  assign busy      = (state_q != S_IDLE);
  assign req_ready = (state_q == S_IDLE);
  assign illegal   = ill_q;
  assign mem_write = (op_q == OP_PUSH);
  assign mem_wide  = wide_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = rf_rdata;
  assign rf_raddr  = (state_q == S_MEM) ? cur : 5'd0;
  assign pc_target = ra_q;

  always_comb begin
    state_d   = state_q;
    op_d      = op_q;
    wide_d    = wide_q;
    pend_d    = pend_q;
    addr_d    = addr_q;
    spnew_d   = spnew_q;
    ra_d      = ra_q;
    ill_d     = 1'b0;
    dat_en    = 1'b0;
    mem_valid = 1'b0;
    rf_we     = 1'b0;
    rf_waddr  = '0;
    rf_wdata  = '0;
    pc_valid  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          if (dec_bad) begin
            ill_d = 1'b1;
          end else begin
            dat_en  = 1'b1;
            op_d    = op_e'(req_op);
            wide_d  = req_wide;
            pend_d  = dec_map;
            if (op_e'(req_op) == OP_PUSH) begin
              addr_d  = req_sp - step_in;
              spnew_d = req_sp - frame;
            end else begin
              addr_d  = req_sp + frame - step_in;
              spnew_d = req_sp + frame;
            end
            state_d = S_MEM;
          end
        end
      end
      S_MEM: begin
        mem_valid = 1'b1;
        if (mem_ready) begin
          dat_en = 1'b1;
          if (op_q == OP_PUSH) begin
            pend_d  = pend_clr;
            addr_d  = addr_q - step_q;
            state_d = (pend_clr == '0) ? S_SP : S_MEM;
          end else begin
            state_d = S_RESP;
          end
        end
      end
      S_RESP: begin
        if (mem_rvalid) begin
          dat_en   = 1'b1;
          rf_we    = 1'b1;
          rf_waddr = cur;
          rf_wdata = mem_rdata;
          if (cur == IDX_W'(REG_RA)) ra_d = mem_rdata;
          pend_d  = pend_clr;
          addr_d  = addr_q - step_q;
          state_d = (pend_clr == '0) ? S_SP : S_MEM;
        end
      end
      S_SP: begin
        rf_we    = 1'b1;
        rf_waddr = 5'(REG_SP);
        rf_wdata = spnew_q;
        unique case (op_q)
          OP_POPRETZ: state_d = S_ZERO;
          OP_POPRET:  state_d = S_RET;
          default:    state_d = S_IDLE;
        endcase
      end
      S_ZERO: begin
        rf_we    = 1'b1;
        rf_waddr = 5'(REG_A0);
        rf_wdata = '0;
        state_d  = S_RET;
      end
      S_RET: begin
        pc_valid = 1'b1;
        state_d  = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ill_q   <= 1'b0;
      op_q    <= OP_PUSH;
      wide_q  <= 1'b0;
      pend_q  <= '0;
    end else begin
      state_q <= state_d;
      ill_q   <= ill_d;
      if (dat_en) begin
        op_q   <= op_d;
        wide_q <= wide_d;
        pend_q <= pend_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (dat_en) begin
      addr_q  <= addr_d;
      spnew_q <= spnew_d;
      ra_q    <= ra_d;
    end
  end
endmodule

// File: rtl/pushpop_seq_chk.sv
module pushpop_seq_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            req_ready,
  input logic            illegal,
  input logic            mem_valid,
  input logic            mem_ready,
  input logic            mem_write,
  input logic [XLEN-1:0] mem_addr,
  input logic            rf_we,
  input logic [4:0]      rf_waddr,
  input logic            pc_valid
);
  a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));

  a_r2_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!busy && !mem_valid && !rf_we && !pc_valid));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_valid && !rf_we && !pc_valid));

  a_r8_redirect_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    pc_valid |-> (busy && $past(rf_we)));

  a_r8_zero_then_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && rf_waddr == 5'd10 && !mem_valid && $past(rf_we) && $past(rf_waddr) == 5'd2)
      |=> pc_valid);
endmodule

bind pushpop_seq pushpop_seq_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .req_ready(req_ready),
  .illegal(illegal), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_write(mem_write), .mem_addr(mem_addr), .rf_we(rf_we),
  .rf_waddr(rf_waddr), .pc_valid(pc_valid)
);

// File: tb/pushpop_seq_bench.sv
module pushpop_seq_bench;
  localparam int XLEN = 64;
  localparam int ADJ_W = 8;
  localparam int K_MEMW = 0, K_MEMR = 1, K_RFW = 2, K_PC = 3, K_ILL = 4;

  typedef struct {
    int          kind;
    logic [63:0] a;
    logic [63:0] d;
    string       tag;
  } ev_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = '0;
  logic [3:0] req_list = '0;
  logic [ADJ_W-1:0] req_extra = '0;
  logic req_wide = 1'b0, req_reduced = 1'b0;
  logic [XLEN-1:0] req_sp = '0;
  logic req_ready, busy, illegal, rf_we, mem_valid, mem_write, mem_wide, pc_valid;
  logic [4:0] rf_raddr, rf_waddr;
  logic [XLEN-1:0] rf_rdata, rf_wdata, mem_addr, mem_wdata, pc_target;
  logic mem_ready = 1'b0, mem_rvalid = 1'b0;
  logic [XLEN-1:0] mem_rdata = '0;

  logic [63:0] regs [32];
  ev_t exp_q[$];
  int errors = 0, checks = 0, cycles = 0;
  logic [7:0] lfsr = 8'h5B;
  logic rsp_pend = 1'b0;
  logic [1:0] rsp_dly = '0;
  logic [63:0] rsp_addr = '0;
  logic exp_wide = 1'b0;

  always #5 clk = ~clk;

  pushpop_seq #(.XLEN(XLEN), .ADJ_W(ADJ_W)) u_pushpop_seq (.*);

  assign rf_rdata = regs[rf_raddr];

  function automatic logic [63:0] memfn(logic [63:0] a);
    return {a[31:0] ^ 32'hC3A5_0F1E, a[31:0] + 32'h0000_1111};
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic observe(int kind, logic [63:0] a, logic [63:0] d);
    ev_t e;
    if (exp_q.size() == 0) begin
      check(1'b0, "R11 unexpected activity", 64'(kind), 64'hFFFF);
      return;
    end
    e = exp_q.pop_front();
    check(e.kind == kind, {e.tag, " kind"}, 64'(kind), 64'(e.kind));
    check(e.a == a, {e.tag, " address"}, a, e.a);
    check(e.d == d, {e.tag, " data"}, d, e.d);
  endtask

  // memory driver and monitor
  always @(negedge clk) begin
    if (rst_n) begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_ready = lfsr[0] | lfsr[2];
      mem_rvalid = 1'b0;
      if (rsp_pend) begin
        if (rsp_dly == 2'd0) begin
          mem_rvalid = 1'b1;
          mem_rdata = memfn(rsp_addr);
          rsp_pend = 1'b0;
        end else rsp_dly = rsp_dly - 2'd1;
      end
      #1;
      if (mem_valid && mem_ready) begin
        check(mem_wide == exp_wide, "R3 word size flag", 64'(mem_wide), 64'(exp_wide));
        if (mem_write) observe(K_MEMW, mem_addr, mem_wdata);
        else begin
          observe(K_MEMR, mem_addr, 64'd0);
          rsp_pend = 1'b1;
          rsp_addr = mem_addr;
          rsp_dly = lfsr[3:2];
        end
      end
      if (rf_we) begin
        check(mem_rvalid || rf_waddr == 5'd2 || rf_waddr == 5'd10, "R10 writeback without response",
              64'(rf_waddr), 64'd0);
        observe(K_RFW, 64'(rf_waddr), rf_wdata);
        regs[rf_waddr] = rf_wdata;
      end
      if (pc_valid) observe(K_PC, 64'd0, pc_target);
      if (illegal) observe(K_ILL, 64'd0, 64'd0);
    end
  end

  task automatic push_exp(int kind, logic [63:0] a, logic [63:0] d, string tag);
    ev_t e;
    e.kind = kind; e.a = a; e.d = d; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic run(int op, int code, int extra, bit wide, bit reduced);
    int order[13] = '{1, 8, 9, 18, 19, 20, 21, 22, 23, 24, 25, 26, 27};
    int n, size;
    logic [63:0] sp, total, addr, ra_val;
    bit bad;
    while (busy) @(negedge clk);
    bad = (code < 4) || (reduced && code > 6);
    n = (code < 4) ? 0 : (code == 15) ? 13 : code - 3;
    size = wide ? 8 : 4;
    total = 64'(((n * size + 15) / 16) * 16 + extra);
    sp = regs[2];
    if (bad) push_exp(K_ILL, 0, 0, "R2 rejected list");
    else if (op == 0) begin
      addr = sp - 64'(size);
      for (int i = n - 1; i >= 0; i--) begin
        push_exp(K_MEMW, addr, regs[order[i]], "R1 R5 R6 push store");
        addr = addr - 64'(size);
      end
      push_exp(K_RFW, 64'd2, sp - total, "R4 R6 push sp");
    end else begin
      addr = sp + total - 64'(size);
      ra_val = '0;
      for (int i = n - 1; i >= 0; i--) begin
        push_exp(K_MEMR, addr, 64'd0, "R1 R5 R7 pop load");
        push_exp(K_RFW, 64'(order[i]), memfn(addr), "R7 R10 pop writeback");
        if (order[i] == 1) ra_val = memfn(addr);
        addr = addr - 64'(size);
      end
      push_exp(K_RFW, 64'd2, sp + total, "R4 R7 pop sp");
      if (op == 3) push_exp(K_RFW, 64'd10, 64'd0, "R8 zero a0");
      if (op >= 2) push_exp(K_PC, 64'd0, ra_val, "R8 redirect");
    end
    exp_wide = wide;
    req_op = 2'(op); req_list = 4'(code); req_extra = 8'(extra);
    req_wide = wide; req_reduced = reduced; req_sp = sp; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    #2;
    if (!bad) check(busy && !req_ready, "R11 busy after accept", 64'(busy), 64'd1);
    else check(!busy, "R2 stays idle", 64'(busy), 64'd0);
    while (busy) @(negedge clk);
    @(negedge clk); @(negedge clk);
    check(exp_q.size() == 0, "R11 sequence complete", 64'(exp_q.size()), 64'd0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = {32'hA000_0000 | 32'(i), 32'(i) * 32'h0101_0101};
    regs[2] = 64'h0000_0000_8000_1000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    check(!busy && req_ready && !mem_valid && !rf_we && !pc_valid && !illegal,
          "R11 reset state", {59'd0, busy, req_ready, mem_valid, rf_we, pc_valid}, 64'h8);
    run(0, 4, 0, 1'b0, 1'b0);
    run(0, 15, 32, 1'b1, 1'b0);
    run(1, 6, 0, 1'b0, 1'b0);
    run(2, 7, 16, 1'b1, 1'b0);
    run(3, 15, 0, 1'b0, 1'b0);
    run(0, 2, 0, 1'b1, 1'b0);
    run(1, 9, 0, 1'b0, 1'b1);
    run(0, 6, 48, 1'b0, 1'b1);
    run(1, 12, 0, 1'b1, 1'b0);
    run(3, 5, 16, 1'b1, 1'b0);
    run(2, 0, 0, 1'b0, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL R11 watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule